// File: doc/BRIEF.md
# Select-and-Capture Status Register with Interrupt Mask

This block keeps the status bits of a communications controller and presents them to a host over a small synchronous bus. Each status bit is one of two kinds, chosen by a parameter. An event-held bit records that its event happened and keeps that record. A live bit shows its input condition as it is in the present cycle.

Retrieval is a two-step procedure. First, the host writes a selection byte to the status address. For every one in that byte, the held value of the event bit is copied into a capture register and the held bit is cleared. Every zero leaves both the captured copy and the held bit as they were. The host then reads the status address. It gets the captured copies for event-held bits and the present input for live bits.

A mask register decides which bits may drive the single active-high interrupt line.

Top module: `stsel_status_reg`

## Requirements
- R1: An event-held bit becomes one in the cycle after its condition input is high. It stays one until a selection write with a one in its position retrieves it.
- R2: Once an event-held bit has been retrieved and cleared, later selection writes capture zero for it until its condition input is high again.
- R3: Reading the status address (address 0) returns the present condition input for every live bit, whatever was written before.
- R4: A write to address 0 copies the held value of each event-held bit whose data bit is one into the capture register, and clears that held bit.
- R5: For each data bit written as zero at address 0, the captured copy keeps its previous value and the held bit is left unchanged.
- R6: A selection write has no effect on live bits: their read value still follows the condition input.
- R7: The mask register sits at address 1. A write stores the data byte, and a read returns it. Reads of addresses 2 and 3 return zero, and writes to them change nothing.
- R8: The interrupt output is registered. In each cycle it equals the OR, over all bits, of the mask bit AND the status value of the previous cycle: the held value for event-held bits and the condition input for live bits.
- R9: If a bit's condition input is high in the same cycle as a selection write that clears it, the capture register takes the value held before the write, and the held bit stays one.
- R10: After synchronous reset, the held bits, the capture register, the mask, the read data and the interrupt output are all zero.
- R11: Read data is registered. It changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | WIDTH | Per-bit event (event-held bits) or condition (live bits) |
| bus_we_i | input | 1 | Host write strobe |
| bus_re_i | input | 1 | Host read strobe |
| bus_addr_i | input | 2 | Host register address |
| bus_wdata_i | input | WIDTH | Host write data |
| bus_rdata_o | output | WIDTH | Registered host read data |
| irq_o | output | 1 | Active-high interrupt |

## Verification
The bench builds the block with WIDTH = 8 and a kind map that makes bits 0 to 5 event-held and bits 6 and 7 live. Both kinds therefore share one selection byte and one read. This shows selection ones landing on live positions without effect, while the captured copies of neighbouring event bits persist. The same build lets the interrupt be driven either by a held event or by a live level under one mask register. It also gives the same-cycle event-and-clear case, which is possible only on an event-held bit.

// File: rtl/stsel_pkg.sv
package stsel_pkg;

    localparam int unsigned BUS_ADDR_W = 2;

    localparam logic [BUS_ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [BUS_ADDR_W-1:0] ADDR_MASK   = 2'd1;

    typedef enum logic [1:0] {
        RSEL_STATUS = 2'd0,
        RSEL_MASK   = 2'd1,
        RSEL_NONE   = 2'd2
    } rsel_e;

    typedef struct packed {
        logic  wr_status;
        logic  wr_mask;
        logic  rd_any;
        rsel_e rsel;
    } acc_dec_t;

    function automatic rsel_e addr_to_rsel(input logic [BUS_ADDR_W-1:0] a);
        rsel_e r;
        case (a)
            ADDR_STATUS: r = RSEL_STATUS;
            ADDR_MASK:   r = RSEL_MASK;
            default:     r = RSEL_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/stsel_decode.sv
module stsel_decode
    import stsel_pkg::*;
(
    input  logic                  we_i,
    input  logic                  re_i,
    input  logic [BUS_ADDR_W-1:0] addr_i,
    output acc_dec_t              dec_o
);
    rsel_e sel;

    always_comb begin
        sel             = addr_to_rsel(addr_i);
        dec_o.rsel      = sel;
        dec_o.rd_any    = re_i;
        dec_o.wr_status = we_i && (sel == RSEL_STATUS);
        dec_o.wr_mask   = we_i && (sel == RSEL_MASK);
    end
endmodule

// File: rtl/stsel_latch_bank.sv
module stsel_latch_bank #(
    parameter int unsigned WIDTH      = 8,
    parameter logic [WIDTH-1:0] LATCH_MASK = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cond_i,
    input  logic             sel_we_i,
    input  logic [WIDTH-1:0] sel_data_i,
    output logic [WIDTH-1:0] held_o,
    output logic [WIDTH-1:0] cap_o,
    output logic [WIDTH-1:0] eff_o,
    output logic [WIDTH-1:0] view_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (LATCH_MASK[i]) begin : g_evt
            logic held_q;
            logic cap_q;
            logic take;

            assign take = sel_we_i & sel_data_i[i];

            always_ff @(posedge clk) begin
                if (rst) begin
                    held_q <= 1'b0;
                    cap_q  <= 1'b0;
                end else begin
                    held_q <= cond_i[i] | (held_q & ~take);
                    if (take) begin
                        cap_q <= held_q;
                    end
                end
            end

            assign held_o[i] = held_q;
            assign cap_o[i]  = cap_q;
            assign eff_o[i]  = held_q;
            assign view_o[i] = cap_q;
        end else begin : g_live
            assign held_o[i] = 1'b0;
            assign cap_o[i]  = 1'b0;
            assign eff_o[i]  = cond_i[i];
            assign view_o[i] = cond_i[i];
        end
    end
endmodule

// File: rtl/stsel_irq_gen.sv
module stsel_irq_gen #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] eff_i,
    input  logic [WIDTH-1:0] mask_i,
    output logic             irq_o
);
    logic [WIDTH-1:0] armed;
    logic             irq_q;

    assign armed = eff_i & mask_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |armed;
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/stsel_status_reg.sv
module stsel_status_reg
    import stsel_pkg::*;
#(
    parameter int unsigned WIDTH      = 8,
    parameter logic [WIDTH-1:0] LATCH_MASK = 8'h3F
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WIDTH-1:0]      cond_i,
    input  logic                  bus_we_i,
    input  logic                  bus_re_i,
    input  logic [BUS_ADDR_W-1:0] bus_addr_i,
    input  logic [WIDTH-1:0]      bus_wdata_i,
    output logic [WIDTH-1:0]      bus_rdata_o,
    output logic                  irq_o
);
    acc_dec_t         dec;
    logic [WIDTH-1:0] held_q;
    logic [WIDTH-1:0] cap_q;
    logic [WIDTH-1:0] eff;
    logic [WIDTH-1:0] view;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] rdata_q;
    logic [WIDTH-1:0] rd_next;

    stsel_decode u_dec (
        .we_i   (bus_we_i),
        .re_i   (bus_re_i),
        .addr_i (bus_addr_i),
        .dec_o  (dec)
    );

    stsel_latch_bank #(
        .WIDTH      (WIDTH),
        .LATCH_MASK (LATCH_MASK)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .cond_i     (cond_i),
        .sel_we_i   (dec.wr_status),
        .sel_data_i (bus_wdata_i),
        .held_o     (held_q),
        .cap_o      (cap_q),
        .eff_o      (eff),
        .view_o     (view)
    );

    stsel_irq_gen #(
        .WIDTH (WIDTH)
    ) u_irq (
        .clk    (clk),
        .rst    (rst),
        .eff_i  (eff),
        .mask_i (mask_q),
        .irq_o  (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (dec.wr_mask) begin
            mask_q <= bus_wdata_i;
        end
    end

    always_comb begin
        case (dec.rsel)
            RSEL_STATUS: rd_next = view;
            RSEL_MASK:   rd_next = mask_q;
            default:     rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (dec.rd_any) begin
            rdata_q <= rd_next;
        end
    end

    assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/stsel_status_reg_chk.sv
module stsel_status_reg_chk #(
    parameter int unsigned WIDTH      = 8,
    parameter logic [WIDTH-1:0] LATCH_MASK = 8'h3F
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] cond_i,
    input logic             bus_we_i,
    input logic             bus_re_i,
    input logic [1:0]       bus_addr_i,
    input logic [WIDTH-1:0] bus_wdata_i,
    input logic [WIDTH-1:0] bus_rdata_o,
    input logic             irq_o,
    input logic [WIDTH-1:0] held_q,
    input logic [WIDTH-1:0] cap_q,
    input logic [WIDTH-1:0] mask_q
);
    logic             sts_wr;
    logic [WIDTH-1:0] status_now;

    assign sts_wr     = bus_we_i && (bus_addr_i == 2'd0);
    assign status_now = (held_q & LATCH_MASK) | (cond_i & ~LATCH_MASK);

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((held_q & $past(cond_i & LATCH_MASK)) == $past(cond_i & LATCH_MASK))); // R1

    AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        sts_wr |=> ((held_q & $past(bus_wdata_i & LATCH_MASK & ~cond_i)) == '0)); // R4

    AST_CAP_STABLE: assert property (@(posedge clk) disable iff (rst)
        !sts_wr |=> $stable(cap_q)); // R5

    AST_CAP_TAKES: assert property (@(posedge clk) disable iff (rst)
        sts_wr |=> ((cap_q & $past(bus_wdata_i & LATCH_MASK)) == $past(held_q & bus_wdata_i & LATCH_MASK))); // R9

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_we_i && bus_addr_i == 2'd1) |=> (mask_q == $past(bus_wdata_i))); // R7

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(|(status_now & mask_q)))); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_re_i |=> $stable(bus_rdata_o)); // R11
endmodule

bind stsel_status_reg stsel_status_reg_chk #(
    .WIDTH      (WIDTH),
    .LATCH_MASK (LATCH_MASK)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cond_i      (cond_i),
    .bus_we_i    (bus_we_i),
    .bus_re_i    (bus_re_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .held_q      (held_q),
    .cap_q       (cap_q),
    .mask_q      (mask_q)
);

// File: tb/stsel_status_reg_test.sv
module stsel_status_reg_test;
    localparam int unsigned W = 8;
    localparam logic [W-1:0] LM = 8'h3F;

    // vector: {event pulse, live level, selection byte, expected read}
    localparam int NVEC = 6;
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h01, 8'h00, 8'h01, 8'h01},
        {8'h06, 8'h80, 8'h02, 8'h83},
        {8'h00, 8'h40, 8'h3F, 8'h44},
        {8'h00, 8'hC0, 8'h04, 8'hC0},
        {8'h30, 8'h00, 8'h00, 8'h00},
        {8'h00, 8'h00, 8'hF0, 8'h30}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] cond = '0;
    logic         we = 1'b0;
    logic         re = 1'b0;
    logic [1:0]   addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stsel_status_reg #(.WIDTH(W), .LATCH_MASK(LM)) uut (
        .clk         (clk),
        .rst         (rst),
        .cond_i      (cond),
        .bus_we_i    (we),
        .bus_re_i    (re),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        re = 1'b1; addr = a;
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input logic [W-1:0] ev, input logic [W-1:0] live);
        @(negedge clk);
        cond = ev | live;
        @(negedge clk);
        cond = live;
    endtask

    task automatic settle;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [W-1:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10 rdata", rdata, 8'h00);
        check("R10 irq", {7'd0, irq}, 8'h00);
        bus_read(2'd1, v);
        check("R10 mask", v, 8'h00);
        bus_write(2'd0, 8'hFF);
        bus_read(2'd0, v);
        check("R10 capture", v, 8'h00);

        // table walk: R1 R2 R3 R4 R5 R6
        for (int k = 0; k < NVEC; k++) begin
            pulse(VEC[k][31:24], VEC[k][23:16]);
            bus_write(2'd0, VEC[k][15:8]);
            bus_read(2'd0, v);
            check($sformatf("R1/R2/R3/R4/R5/R6 vector %0d", k), v, VEC[k][7:0]);
        end
        cond = '0;

        // R11: read data holds without strobe
        settle();
        check("R11 hold", rdata, 8'h30);

        // R7: mask register and unused addresses
        bus_write(2'd1, 8'hA5);
        bus_read(2'd1, v);
        check("R7 mask readback", v, 8'hA5);
        bus_write(2'd2, 8'hFF);
        bus_read(2'd2, v);
        check("R7 unused read", v, 8'h00);
        bus_read(2'd1, v);
        check("R7 mask untouched", v, 8'hA5);

        // R9: event in the same cycle as its clear
        bus_write(2'd1, 8'h00);
        pulse(8'h01, 8'h00);
        @(negedge clk);
        we = 1'b1; addr = 2'd0; wdata = 8'h01; cond = 8'h01;
        @(negedge clk);
        we = 1'b0; wdata = '0; cond = '0;
        bus_read(2'd0, v);
        check("R9 capture pre-clear", v, 8'h31);
        bus_write(2'd0, 8'h01);
        bus_read(2'd0, v);
        check("R9 latch stays set", v, 8'h31);
        bus_write(2'd0, 8'h01);
        bus_read(2'd0, v);
        check("R2 cleared after retrieval", v, 8'h30);

        // R8: interrupt masking
        bus_write(2'd1, 8'h01);
        pulse(8'h02, 8'h00);
        settle();
        check("R8 masked event", {7'd0, irq}, 8'h00);
        pulse(8'h01, 8'h00);
        settle();
        check("R8 unmasked event", {7'd0, irq}, 8'h01);
        bus_write(2'd0, 8'h01);
        settle();
        check("R8 cleared event", {7'd0, irq}, 8'h00);
        bus_write(2'd1, 8'h80);
        @(negedge clk);
        cond = 8'h80;
        settle();
        check("R8 live level high", {7'd0, irq}, 8'h01);
        bus_write(2'd0, 8'hC0);
        settle();
        check("R6 live irq after selection", {7'd0, irq}, 8'h01);
        cond = 8'h00;
        settle();
        check("R8 live level low", {7'd0, irq}, 8'h00);
        bus_write(2'd1, 8'h02);
        settle();
        check("R8 mask of held bit", {7'd0, irq}, 8'h01);
        bus_write(2'd1, 8'h00);
        settle();
        check("R8 mask removed", {7'd0, irq}, 8'h00);

        // R10: reset mid-run clears held state
        bus_write(2'd1, 8'hFF);
        pulse(8'h3F, 8'h00);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 irq after reset", {7'd0, irq}, 8'h00);
        bus_read(2'd1, v);
        check("R10 mask after reset", v, 8'h00);
        bus_write(2'd0, 8'hFF);
        bus_read(2'd0, v);
        check("R10 latches after reset", v, 8'h00);

        finish_run();
    end
endmodule